// File: doc/BRIEF.md
# Segmented Bus Switch Route Controller

This block is the central control point for the switches of one or more segmented buses. In every cycle each bus lane presents the address of its current access, the number of the requester and the direction of the transfer. The block matches the address against a set of programmable address windows to find the target component. It then reads a route word from a writable table indexed by target, requester and direction. On the next clock edge it drives that word onto the switch control wires, so a path is in place one cycle after the access is seen.

There is no arbitration and no handshake: the schedule is fixed ahead of time so that accesses never conflict. Software fills the address windows and the route table through a plain write-only register port. Each bus lane has its own route table and its own control outputs, and all lanes share one set of address windows. When a lane has no access the control wires hold their last value. An access that falls outside every window parks every switch of that lane at the idle code.

Top module: `swc_switch_ctrl`

## Requirements
- R1: While reset is asserted, and after reset until the first access that changes them, every 4-bit switch code on `sw_ctrl` equals the idle code (default 4'hC).
- R2: An access address `a` matches window `t` when `(a & mask_t) == (base_t & mask_t)`; a mask bit of 0 makes that address bit a don't-care.
- R3: When an address matches several windows, the window with the lowest number is the target.
- R4: For a valid access that matches a window, `sw_ctrl` for that lane shows, after the next rising clock edge, the route table entry stored at (lane, target, requester `acc_src`, direction `acc_write`, 1 = write).
- R5: For a valid access that matches no window, every switch code of that lane becomes the idle code after the next rising edge.
- R6: In a cycle where a lane's `acc_valid` is 0, that lane's `sw_ctrl` is unchanged after the next edge, whatever its address, source and direction inputs are.
- R7: A configuration write takes `cfg_addr` as {region[1:0], index}, where region 0 writes window base `index[TGT_W-1:0]`, region 1 writes that window's mask, and region 2 writes a route entry with the index read as {lane, target, requester, direction}, direction in bit 0. The new value is the low bits of `cfg_wdata`. Region 3 writes change nothing.
- R8: An access in the same cycle as a write to the entry it selects uses the old entry; accesses in later cycles use the new one.
- R9: Each lane has its own route table. A write to one lane's entry does not change what another lane drives for the same target, requester and direction.
- R10: Within a lane's `ENT_W`-bit slice of `sw_ctrl` (lane `b` at bits `b*ENT_W`), switch `s` takes bits `[4s+3:4s]`. These are route entry bits `[4s+3:4s]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_AW (7) | Configuration write address: region and index |
| cfg_wdata | input | CFG_DW (32) | Configuration write data |
| acc_valid | input | N_BUS (2) | Per-lane access present |
| acc_addr | input | N_BUS*ADDR_W (32) | Per-lane access address |
| acc_src | input | N_BUS*SRC_W (2) | Per-lane requester number |
| acc_write | input | N_BUS (2) | Per-lane direction, 1 = write |
| sw_ctrl | output | N_BUS*ENT_W (48) | Per-lane switch control codes, 4 bits per switch |

## Verification
The bench builds the block with its defaults: two lanes, four address windows, two requesters and six switches. With these values the route table holds 32 entries, every index field is fully used, and lane independence can be observed directly. Four windows allow an overlapping layout with a wide window under narrow ones, which exercises the lowest-number priority, partial masks and a real miss gap. Six distinct codes per entry make any swap of switch fields visible.

// File: rtl/swc_pkg.sv
package swc_pkg;

   // width of one switch control code
   localparam int CODE_W = 4;

   // configuration regions, selected by the top two bits of the write address
   typedef enum logic [1:0] {
      RG_BASE  = 2'd0,
      RG_MASK  = 2'd1,
      RG_TABLE = 2'd2,
      RG_NONE  = 2'd3
   } cfg_region_e;

endpackage

// File: rtl/swc_range_bank.sv
module swc_range_bank #(
   parameter int ADDR_W = 16,
   parameter int N_TGT  = 4,
   parameter int N_BUS  = 2,
   parameter int TGT_W  = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_base,
   input  logic                      wr_mask,
   input  logic [TGT_W-1:0]          wr_sel,
   input  logic [ADDR_W-1:0]         wr_data,
   input  logic [N_BUS*ADDR_W-1:0]   look_addr,
   output logic [N_BUS-1:0]          look_hit,
   output logic [N_BUS*TGT_W-1:0]    look_tgt,
   output logic [N_TGT*ADDR_W-1:0]   base_flat,
   output logic [N_TGT*ADDR_W-1:0]   mask_flat
);

   logic [ADDR_W-1:0] base_q [N_TGT];
   logic [ADDR_W-1:0] mask_q [N_TGT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int t = 0; t < N_TGT; t++) begin
            base_q[t] <= '0;
            mask_q[t] <= '0;
         end
      end else if (int'(wr_sel) < N_TGT) begin
         if (wr_base) base_q[wr_sel] <= wr_data;
         if (wr_mask) mask_q[wr_sel] <= wr_data;
      end
   end

   for (genvar t = 0; t < N_TGT; t++) begin : g_flat
      assign base_flat[t*ADDR_W +: ADDR_W] = base_q[t];
      assign mask_flat[t*ADDR_W +: ADDR_W] = mask_q[t];
   end

   // one priority matcher per lane; lowest window number wins
   for (genvar b = 0; b < N_BUS; b++) begin : g_lane
      logic [ADDR_W-1:0] a;
      logic              hit_c;
      logic [TGT_W-1:0]  tgt_c;

      assign a = look_addr[b*ADDR_W +: ADDR_W];

      always_comb begin
         hit_c = 1'b0;
         tgt_c = '0;
         for (int t = N_TGT - 1; t >= 0; t--) begin
            if ((a & mask_q[t]) == (base_q[t] & mask_q[t])) begin
               hit_c = 1'b1;
               tgt_c = TGT_W'(t);
            end
         end
      end

      assign look_hit[b]                  = hit_c;
      assign look_tgt[b*TGT_W +: TGT_W]   = tgt_c;
   end

endmodule

// File: rtl/swc_route_table.sv
module swc_route_table #(
   parameter int   N_BUS  = 2,
   parameter int   N_TGT  = 4,
   parameter int   N_SRC  = 2,
   parameter int   TGT_W  = 2,
   parameter int   SRC_W  = 1,
   parameter int   BUS_W  = 1,
   parameter int   ENT_W  = 24,
   parameter logic [ENT_W-1:0] IDLE_FILL = '0,
   localparam int  N_ENT  = N_TGT * N_SRC * 2,
   localparam int  ENT_IW = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [BUS_W-1:0]         wr_bus,
   input  logic [TGT_W-1:0]         wr_tgt,
   input  logic [SRC_W-1:0]         wr_src,
   input  logic                     wr_dir,
   input  logic [ENT_W-1:0]         wr_data,
   input  logic [N_BUS*TGT_W-1:0]   rd_tgt,
   input  logic [N_BUS*SRC_W-1:0]   rd_src,
   input  logic [N_BUS-1:0]         rd_dir,
   output logic [N_BUS*ENT_W-1:0]   rd_entry
);

   logic [ENT_W-1:0] mem_q [N_BUS][N_ENT];

   function automatic int ent_pos(logic [TGT_W-1:0] t, logic [SRC_W-1:0] s, logic d);
      return (int'(t) * N_SRC + int'(s)) * 2 + int'(d);
   endfunction

   logic wr_ok;
   assign wr_ok = wr_en && (int'(wr_bus) < N_BUS) && (int'(wr_tgt) < N_TGT)
                  && (int'(wr_src) < N_SRC);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int b = 0; b < N_BUS; b++)
            for (int e = 0; e < N_ENT; e++)
               mem_q[b][e] <= IDLE_FILL;
      end else if (wr_ok) begin
         mem_q[wr_bus][ENT_IW'(ent_pos(wr_tgt, wr_src, wr_dir))] <= wr_data;
      end
   end

   for (genvar b = 0; b < N_BUS; b++) begin : g_rd
      int               pos;
      logic [ENT_W-1:0] ent_c;

      always_comb begin
         pos = ent_pos(rd_tgt[b*TGT_W +: TGT_W], rd_src[b*SRC_W +: SRC_W], rd_dir[b]);
         if (pos < N_ENT) ent_c = mem_q[b][ENT_IW'(pos)];
         else             ent_c = IDLE_FILL;
      end

      assign rd_entry[b*ENT_W +: ENT_W] = ent_c;
   end

endmodule

// File: rtl/swc_out_stage.sv
module swc_out_stage #(
   parameter int   ENT_W = 24,
   parameter logic [ENT_W-1:0] IDLE_FILL = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_vld,
   input  logic              route_hit,
   input  logic [ENT_W-1:0]  route_word,
   output logic [ENT_W-1:0]  ctrl_q
);

   logic [ENT_W-1:0] nxt;
   logic             load;

   // a new word is loaded only when an access is present and the word differs,
   // so the control wires never toggle without need
   always_comb begin
      nxt  = route_hit ? route_word : IDLE_FILL;
      load = acc_vld && (nxt != ctrl_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    ctrl_q <= IDLE_FILL;
      else if (load) ctrl_q <= nxt;
   end

endmodule

// File: rtl/swc_switch_ctrl.sv
module swc_switch_ctrl
   import swc_pkg::*;
#(
   parameter int   ADDR_W    = 16,
   parameter int   N_BUS     = 2,
   parameter int   N_TGT     = 4,
   parameter int   N_SRC     = 2,
   parameter int   N_SW      = 6,
   parameter int   CFG_DW    = 32,
   parameter logic [CODE_W-1:0] IDLE_CODE = 4'hC,
   localparam int  TGT_W     = (N_TGT > 1) ? $clog2(N_TGT) : 1,
   localparam int  SRC_W     = (N_SRC > 1) ? $clog2(N_SRC) : 1,
   localparam int  BUS_W     = (N_BUS > 1) ? $clog2(N_BUS) : 1,
   localparam int  ENT_W     = N_SW * CODE_W,
   localparam int  IDX_W     = BUS_W + TGT_W + SRC_W + 1,
   localparam int  CFG_AW    = IDX_W + 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cfg_we,
   input  logic [CFG_AW-1:0]        cfg_addr,
   input  logic [CFG_DW-1:0]        cfg_wdata,
   input  logic [N_BUS-1:0]         acc_valid,
   input  logic [N_BUS*ADDR_W-1:0]  acc_addr,
   input  logic [N_BUS*SRC_W-1:0]   acc_src,
   input  logic [N_BUS-1:0]         acc_write,
   output logic [N_BUS*ENT_W-1:0]   sw_ctrl
);

   localparam logic [ENT_W-1:0] IDLE_FILL = {N_SW{IDLE_CODE}};

   // elaboration-time parameter checks
   if (N_BUS < 1 || N_TGT < 1 || N_SRC < 1 || N_SW < 1) begin : g_bad_count
      $error("swc_switch_ctrl: counts must be at least 1");
   end
   if (ADDR_W > CFG_DW) begin : g_bad_addr
      $error("swc_switch_ctrl: ADDR_W exceeds CFG_DW");
   end
   if (ENT_W > CFG_DW) begin : g_bad_ent
      $error("swc_switch_ctrl: route entry wider than CFG_DW");
   end

   // configuration address split
   cfg_region_e      cfg_rgn;
   logic [IDX_W-1:0] cfg_idx;
   logic             wr_base, wr_mask, wr_tbl;
   logic             wr_dir;
   logic [SRC_W-1:0] wr_src;
   logic [TGT_W-1:0] wr_tgt;
   logic [BUS_W-1:0] wr_bus;

   assign cfg_rgn = cfg_region_e'(cfg_addr[CFG_AW-1 -: 2]);
   assign cfg_idx = cfg_addr[IDX_W-1:0];
   assign wr_base = cfg_we && (cfg_rgn == RG_BASE);
   assign wr_mask = cfg_we && (cfg_rgn == RG_MASK);
   assign wr_tbl  = cfg_we && (cfg_rgn == RG_TABLE);
   assign wr_dir  = cfg_idx[0];
   assign wr_src  = cfg_idx[SRC_W:1];
   assign wr_tgt  = cfg_idx[SRC_W+TGT_W:SRC_W+1];
   assign wr_bus  = cfg_idx[IDX_W-1 -: BUS_W];

   wire unused_cfg_bits = ^cfg_wdata;

   // address window matching
   logic [N_BUS-1:0]        dec_hit;
   logic [N_BUS*TGT_W-1:0]  dec_tgt;
   logic [N_TGT*ADDR_W-1:0] rng_base;
   logic [N_TGT*ADDR_W-1:0] rng_mask;

   swc_range_bank #(
      .ADDR_W (ADDR_W),
      .N_TGT  (N_TGT),
      .N_BUS  (N_BUS),
      .TGT_W  (TGT_W)
   ) u_range (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_base   (wr_base),
      .wr_mask   (wr_mask),
      .wr_sel    (cfg_idx[TGT_W-1:0]),
      .wr_data   (cfg_wdata[ADDR_W-1:0]),
      .look_addr (acc_addr),
      .look_hit  (dec_hit),
      .look_tgt  (dec_tgt),
      .base_flat (rng_base),
      .mask_flat (rng_mask)
   );

   // route storage
   logic [N_BUS*ENT_W-1:0] tbl_entry;

   swc_route_table #(
      .N_BUS     (N_BUS),
      .N_TGT     (N_TGT),
      .N_SRC     (N_SRC),
      .TGT_W     (TGT_W),
      .SRC_W     (SRC_W),
      .BUS_W     (BUS_W),
      .ENT_W     (ENT_W),
      .IDLE_FILL (IDLE_FILL)
   ) u_table (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_tbl),
      .wr_bus   (wr_bus),
      .wr_tgt   (wr_tgt),
      .wr_src   (wr_src),
      .wr_dir   (wr_dir),
      .wr_data  (cfg_wdata[ENT_W-1:0]),
      .rd_tgt   (dec_tgt),
      .rd_src   (acc_src),
      .rd_dir   (acc_write),
      .rd_entry (tbl_entry)
   );

   // per-lane output registers
   logic [N_BUS-1:0] src_ok;

   for (genvar b = 0; b < N_BUS; b++) begin : g_lane
      assign src_ok[b] = int'(acc_src[b*SRC_W +: SRC_W]) < N_SRC;

      swc_out_stage #(
         .ENT_W     (ENT_W),
         .IDLE_FILL (IDLE_FILL)
      ) u_out (
         .clk        (clk),
         .rst_n      (rst_n),
         .acc_vld    (acc_valid[b]),
         .route_hit  (dec_hit[b] && src_ok[b]),
         .route_word (tbl_entry[b*ENT_W +: ENT_W]),
         .ctrl_q     (sw_ctrl[b*ENT_W +: ENT_W])
      );
   end

endmodule

// File: rtl/swc_switch_ctrl_chk.sv
module swc_switch_ctrl_chk #(
   parameter int   ADDR_W = 16,
   parameter int   N_BUS  = 2,
   parameter int   N_TGT  = 4,
   parameter int   TGT_W  = 2,
   parameter int   ENT_W  = 24,
   parameter logic [ENT_W-1:0] IDLE_FILL = '0
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic [N_BUS-1:0]         acc_valid,
   input logic [N_BUS*ADDR_W-1:0]  acc_addr,
   input logic [N_BUS-1:0]         dec_hit,
   input logic [N_BUS*TGT_W-1:0]   dec_tgt,
   input logic [N_BUS*ENT_W-1:0]   tbl_entry,
   input logic [N_BUS-1:0]         src_ok,
   input logic [N_TGT*ADDR_W-1:0]  rng_base,
   input logic [N_TGT*ADDR_W-1:0]  rng_mask,
   input logic [N_BUS*ENT_W-1:0]   sw_ctrl
);

   for (genvar b = 0; b < N_BUS; b++) begin : g_chk
      logic [ADDR_W-1:0] sel_base, sel_mask, a;
      logic [TGT_W-1:0]  t;

      always_comb begin
         a        = acc_addr[b*ADDR_W +: ADDR_W];
         t        = dec_tgt[b*TGT_W +: TGT_W];
         sel_base = rng_base[int'(t)*ADDR_W +: ADDR_W];
         sel_mask = rng_mask[int'(t)*ADDR_W +: ADDR_W];
      end

      // R6
      hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !acc_valid[b] |=> $stable(sw_ctrl[b*ENT_W +: ENT_W]));

      // R5
      miss_parks_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (acc_valid[b] && !dec_hit[b]) |=> (sw_ctrl[b*ENT_W +: ENT_W] == IDLE_FILL));

      // R4
      hit_loads_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (acc_valid[b] && dec_hit[b] && src_ok[b])
         |=> (sw_ctrl[b*ENT_W +: ENT_W] == $past(tbl_entry[b*ENT_W +: ENT_W])));

      // R2
      window_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
         dec_hit[b] |-> ((a & sel_mask) == (sel_base & sel_mask)));
   end

endmodule

bind swc_switch_ctrl swc_switch_ctrl_chk #(
   .ADDR_W    (ADDR_W),
   .N_BUS     (N_BUS),
   .N_TGT     (N_TGT),
   .TGT_W     (TGT_W),
   .ENT_W     (ENT_W),
   .IDLE_FILL (IDLE_FILL)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .acc_valid (acc_valid),
   .acc_addr  (acc_addr),
   .dec_hit   (dec_hit),
   .dec_tgt   (dec_tgt),
   .tbl_entry (tbl_entry),
   .src_ok    (src_ok),
   .rng_base  (rng_base),
   .rng_mask  (rng_mask),
   .sw_ctrl   (sw_ctrl)
);

// File: tb/tb_swc_switch_ctrl.sv
module tb_swc_switch_ctrl;

   localparam int ADDR_W = 16;
   localparam int N_BUS  = 2;
   localparam int N_TGT  = 4;
   localparam int N_SRC  = 2;
   localparam int N_SW   = 6;
   localparam int ENT_W  = 24;
   localparam int CFG_AW = 7;
   localparam logic [ENT_W-1:0] IDLE = {N_SW{4'hC}};

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic                    cfg_we = 1'b0;
   logic [CFG_AW-1:0]       cfg_addr = '0;
   logic [31:0]             cfg_wdata = '0;
   logic [N_BUS-1:0]        acc_valid = '0;
   logic [N_BUS*ADDR_W-1:0] acc_addr = '0;
   logic [N_BUS-1:0]        acc_src = '0;
   logic [N_BUS-1:0]        acc_write = '0;
   logic [N_BUS*ENT_W-1:0]  sw_ctrl;

   swc_switch_ctrl dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .acc_valid(acc_valid), .acc_addr(acc_addr),
      .acc_src(acc_src), .acc_write(acc_write), .sw_ctrl(sw_ctrl)
   );

   always #5 clk = ~clk;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // reference model
   logic [ADDR_W-1:0] m_base [N_TGT];
   logic [ADDR_W-1:0] m_mask [N_TGT];
   logic [ENT_W-1:0]  m_tbl  [N_BUS][16];
   logic [ENT_W-1:0]  m_out  [N_BUS];

   task automatic check(string tag, logic [ENT_W-1:0] act, logic [ENT_W-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // lowest matching window, -1 when none (R2, R3)
   function automatic int decode(logic [ADDR_W-1:0] a);
      for (int t = 0; t < N_TGT; t++)
         if ((a & m_mask[t]) == (m_base[t] & m_mask[t])) return t;
      return -1;
   endfunction

   function automatic logic [ENT_W-1:0] make_word(int b, int t, int s, int d);
      logic [ENT_W-1:0] w;
      for (int k = 0; k < N_SW; k++) w[k*4 +: 4] = 4'((b*7 + t*5 + s*3 + d + k) & 15);
      return w;
   endfunction

   function automatic void model_write();
      logic [1:0] rg;
      logic [4:0] ix;
      rg = cfg_addr[6:5];
      ix = cfg_addr[4:0];
      if (!cfg_we) return;
      case (rg)
         2'd0: m_base[ix[1:0]] = cfg_wdata[ADDR_W-1:0];
         2'd1: m_mask[ix[1:0]] = cfg_wdata[ADDR_W-1:0];
         2'd2: m_tbl[ix[4]][(int'(ix[3:2])*2 + int'(ix[1]))*2 + int'(ix[0])] = cfg_wdata[ENT_W-1:0];
         default: ;
      endcase
   endfunction

   // one clock: expectations from present inputs and model, then compare
   task automatic step(string tag_over);
      logic [ENT_W-1:0] exp [N_BUS];
      string            tag [N_BUS];
      for (int b = 0; b < N_BUS; b++) begin
         if (acc_valid[b]) begin
            int t;
            t = decode(acc_addr[b*ADDR_W +: ADDR_W]);
            if (t < 0) begin exp[b] = IDLE; tag[b] = "R5"; end
            else begin
               exp[b] = m_tbl[b][(t*2 + int'(acc_src[b]))*2 + int'(acc_write[b])];
               tag[b] = "R4";
            end
         end else begin
            exp[b] = m_out[b];
            tag[b] = "R6";
         end
         if (tag_over != "") tag[b] = tag_over;
      end
      model_write();
      @(posedge clk);
      @(negedge clk);
      for (int b = 0; b < N_BUS; b++) begin
         check(tag[b], sw_ctrl[b*ENT_W +: ENT_W], exp[b]);
         m_out[b] = exp[b];
      end
   endtask

   task automatic set_acc(int b, bit v, logic [ADDR_W-1:0] a, bit s, bit w);
      acc_valid[b]               = v;
      acc_addr[b*ADDR_W +: ADDR_W] = a;
      acc_src[b]                 = s;
      acc_write[b]               = w;
   endtask

   task automatic cfg_write(logic [1:0] rg, logic [4:0] ix, logic [31:0] d, string tag);
      cfg_we    = 1'b1;
      cfg_addr  = {rg, ix};
      cfg_wdata = d;
      step(tag);
      cfg_we    = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         fails++;
         checks++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2718));
      for (int t = 0; t < N_TGT; t++) begin m_base[t] = '0; m_mask[t] = '0; end
      for (int b = 0; b < N_BUS; b++) begin
         m_out[b] = IDLE;
         for (int e = 0; e < 16; e++) m_tbl[b][e] = IDLE;
      end

      // R1: reset state, then idle hold right after release
      repeat (3) @(negedge clk);
      check("R1", sw_ctrl[0 +: ENT_W], IDLE);
      check("R1", sw_ctrl[ENT_W +: ENT_W], IDLE);
      rst_n = 1'b1;
      set_acc(0, 1'b0, 16'h1234, 1'b1, 1'b1);
      step("R1");

      // R7: windows; window 2 overlaps 0 and 1, 0x4000-0x7FFF is a gap
      cfg_write(2'd0, 5'd0, 32'h0000, "R7");
      cfg_write(2'd1, 5'd0, 32'hF000, "R7");
      cfg_write(2'd0, 5'd1, 32'h1000, "R7");
      cfg_write(2'd1, 5'd1, 32'hF000, "R7");
      cfg_write(2'd0, 5'd2, 32'h0000, "R7");
      cfg_write(2'd1, 5'd2, 32'hC000, "R7");
      cfg_write(2'd0, 5'd3, 32'h8000, "R7");
      cfg_write(2'd1, 5'd3, 32'h8000, "R7");
      for (int b = 0; b < N_BUS; b++)
         for (int t = 0; t < N_TGT; t++)
            for (int s = 0; s < N_SRC; s++)
               for (int d = 0; d < 2; d++)
                  cfg_write(2'd2, 5'(b*16 + t*4 + s*2 + d), 32'(make_word(b, t, s, d)), "R7");

      // R3: 0x0005 matches windows 0 and 2, window 0 wins
      set_acc(0, 1'b1, 16'h0005, 1'b0, 1'b0);
      set_acc(1, 1'b1, 16'h1ABC, 1'b1, 1'b1);
      step("R3");
      // R2: partial mask reaches window 2 at its top edge; window 3 by one bit
      set_acc(0, 1'b1, 16'h3FFF, 1'b1, 1'b0);
      set_acc(1, 1'b1, 16'hF00D, 1'b0, 1'b1);
      step("R2");
      // R5: gap addresses park the lanes
      set_acc(0, 1'b1, 16'h4000, 1'b0, 1'b0);
      set_acc(1, 1'b1, 16'h7FFF, 1'b1, 1'b1);
      step("R5");
      // R6: no access, other inputs moving
      set_acc(0, 1'b0, 16'h1000, 1'b1, 1'b1);
      set_acc(1, 1'b0, 16'h0000, 1'b0, 1'b0);
      step("R6");

      // R10: distinct code per switch, fields checked one at a time
      cfg_write(2'd2, 5'b0_01_0_0, 32'h00543210, "R10");
      set_acc(0, 1'b1, 16'h1234, 1'b0, 1'b0);
      step("R10");
      for (int k = 0; k < N_SW; k++)
         check("R10", ENT_W'(sw_ctrl[k*4 +: 4]), ENT_W'(k));

      // R8: same-cycle write of the selected entry sees the old value
      cfg_we = 1'b1; cfg_addr = {2'd2, 5'b0_01_0_0}; cfg_wdata = 32'h00ABCDEF;
      set_acc(0, 1'b1, 16'h1000, 1'b0, 1'b0);
      set_acc(1, 1'b0, 16'h0000, 1'b0, 1'b0);
      step("R8");
      cfg_we = 1'b0;
      step("R8");

      // R7: region 3 writes change no route
      cfg_write(2'd3, 5'b0_01_0_0, 32'h00111111, "R7");
      set_acc(0, 1'b1, 16'h0100, 1'b0, 1'b0);
      step("R7");
      set_acc(0, 1'b1, 16'h1100, 1'b0, 1'b0);
      step("R7");

      // R9: write lane 1 entry, lane 0 same path keeps its own word
      set_acc(0, 1'b0, 16'h0000, 1'b0, 1'b0);
      cfg_write(2'd2, 5'b1_10_1_1, 32'h00999999, "R9");
      set_acc(0, 1'b1, 16'h2222, 1'b1, 1'b1);
      set_acc(1, 1'b1, 16'h2222, 1'b1, 1'b1);
      step("R9");

      // random traffic mixed with random configuration
      for (int i = 0; i < 400; i++) begin
         cfg_we    = ($urandom % 5) == 0;
         cfg_addr  = CFG_AW'($urandom);
         if (cfg_addr[6:5] != 2'd2 && ($urandom % 4) != 0) cfg_addr[6:5] = 2'd2;
         cfg_wdata = $urandom;
         for (int b = 0; b < N_BUS; b++)
            set_acc(b, ($urandom % 4) != 0, ADDR_W'($urandom), 1'($urandom), 1'($urandom));
         step("");
      end
      cfg_we = 1'b0;

      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule